// File: doc/BRIEF.md
# I/O Port Window Decoder

This block turns the control and address signals of an 8-bit CPU port cycle into active-low select lines for peripherals. Each select line covers a window of 16 port numbers. The block also contains two simple ports. One is an 8-bit output register that captures the write data. The other is an 8-bit input port that drives external pin values onto the read data path.

A port cycle is valid only while the request strobe is low and the opcode-fetch strobe is high. When both strobes are low, the cycle is an interrupt acknowledge, and it selects nothing. The upper address byte is sent on unchanged, so a peripheral can use it as extra information, for example as a keyboard row mask.

A parameter sets the strobe style. In combined mode, a select line ignores the read and write strobes. In direction-qualified mode, the input window's line needs read to be low and the output window's line needs write to be low. The other lines stay combined in both modes.

All interfaces here are plain bus-cycle signals. None of them is a stream, so there is no valid/ready handshake and no back-pressure.

Top module: `io_port_decoder`

## Requirements
- R1: Select line k (`sel_n[k]`, active low) is low only when all of these hold: `iorq_n`=0, `m1_n`=1, address bit 7 = 0, address bits 6..4 = k, and k is not 5 or 6. At most one select line is low at any time.
- R2: When `iorq_n`=0 and `m1_n`=0 (interrupt acknowledge), every select line is high, both strobes are high, `rdata_oe`=0, and the output register does not change.
- R3: For ports 0x50–0x6F and 0x80–0xFF, no select line asserts and `rdata_oe` stays 0.
- R4: With `DIR_QUAL`=1 (the default), line 0 (ports 0x00–0x0F) also needs `rd_n`=0, and line 1 (ports 0x10–0x1F) also needs `wr_n`=0. With `DIR_QUAL`=0, every line ignores `rd_n` and `wr_n`.
- R5: `rdata_oe` is 1 exactly when the cycle is valid, the address is in 0x00–0x0F, and `rd_n`=0. While `rdata_oe` is 1, `rdata` equals `gp_in`.
- R6: A write cycle to 0x00–0x0F (`rd_n`=1) never sets `rdata_oe`.
- R7: On a rising clock edge, if the cycle is valid, the address is in 0x10–0x1F, and `wr_n`=0, `gp_out` takes the value of `wdata`. On every other edge, `gp_out` keeps its value.
- R8: A high `rst` at a rising edge sets `gp_out` to 0x00.
- R9: `hi_addr` always equals `addr[15:8]`.
- R10: `io_rd_n` (or `io_wr_n`) is low exactly when the cycle is valid, the port is in a decoded window, and `rd_n` (or `wr_n`) is 0.
- R11: While `rdata_oe` is 0, `rdata` reads 0xFF, which models a pulled-up bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 16 | Port address |
| iorq_n | input | 1 | I/O request strobe, active low |
| m1_n | input | 1 | Opcode-fetch strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data bus |
| gp_in | input | 8 | External input pins |
| sel_n | output | 8 | Window select lines, active low |
| io_rd_n | output | 1 | Qualified read strobe, active low |
| io_wr_n | output | 1 | Qualified write strobe, active low |
| hi_addr | output | 8 | Upper address byte, passed through |
| gp_out | output | 8 | Output register value |
| rdata | output | 8 | Read data (0xFF when not driven) |
| rdata_oe | output | 1 | Read data drive enable |

## Verification
The assertions assume that bus inputs are stable around each rising clock edge. This matches a CPU that holds address and strobes steady for the whole port cycle. The bench meets this by changing every input only on the falling edge and sampling a short time later.

The bench sweeps every low address byte against all 16 combinations of the four strobes. It runs this sweep on both the direction-qualified and the combined configuration, using varied upper address bytes and pin values.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned GROUPS     = 8;
  localparam int unsigned WIN_SHIFT  = 4;
  localparam int unsigned GRP_BITS   = $clog2(GROUPS);
  localparam int unsigned LO_W       = WIN_SHIFT + GRP_BITS + 1;
  localparam int unsigned IN_LINE    = 0;
  localparam int unsigned OUT_LINE   = 1;

  typedef logic [DATA_W-1:0] dbyte_t;
  typedef logic [GROUPS-1:0] grp_vec_t;

  typedef struct packed {
    logic iorq_n;
    logic m1_n;
    logic rd_n;
    logic wr_n;
  } bus_ctl_t;
endpackage

// File: rtl/io_window_decode.sv
module io_window_decode
  import io_dec_pkg::*;
#(
  parameter int unsigned NGRP      = GROUPS,
  parameter logic [NGRP-1:0] USED  = 8'b1001_1111
) (
  input  logic [LO_W-1:0] addr_lo,
  input  bus_ctl_t        ctl,
  output logic [NGRP-1:0] hit,
  output logic            cyc_ok
);
  logic in_space;

  always_comb begin
    cyc_ok   = !ctl.iorq_n && ctl.m1_n;
    in_space = !addr_lo[LO_W-1];
  end

  for (genvar k = 0; k < NGRP; k++) begin : g_win
    if (USED[k]) begin : g_used
      assign hit[k] = cyc_ok && in_space &&
                      (addr_lo[WIN_SHIFT +: GRP_BITS] == GRP_BITS'(k));
    end else begin : g_unused
      assign hit[k] = 1'b0;
    end
  end
endmodule

// File: rtl/io_strobe_qual.sv
module io_strobe_qual
  import io_dec_pkg::*;
#(
  parameter int unsigned NGRP          = GROUPS,
  parameter bit          DIR_QUAL      = 1'b1,
  parameter logic [NGRP-1:0] RD_ONLY   = 8'b0000_0001,
  parameter logic [NGRP-1:0] WR_ONLY   = 8'b0000_0010
) (
  input  logic [NGRP-1:0] hit,
  input  logic            rd_n,
  input  logic            wr_n,
  output logic [NGRP-1:0] sel_n,
  output logic            io_rd_n,
  output logic            io_wr_n
);
  for (genvar k = 0; k < NGRP; k++) begin : g_line
    if (DIR_QUAL && RD_ONLY[k]) begin : g_rd
      assign sel_n[k] = !(hit[k] && !rd_n);
    end else if (DIR_QUAL && WR_ONLY[k]) begin : g_wr
      assign sel_n[k] = !(hit[k] && !wr_n);
    end else begin : g_comb
      assign sel_n[k] = !hit[k];
    end
  end

  always_comb begin
    io_rd_n = !((|hit) && !rd_n);
    io_wr_n = !((|hit) && !wr_n);
  end
endmodule

// File: rtl/io_gp_ports.sv
module io_gp_ports
  import io_dec_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_sel_n,
  input  logic          out_sel_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] gp_in,
  output logic [DW-1:0] gp_out,
  output logic [DW-1:0] rdata,
  output logic          rdata_oe
);
  logic load;

  always_comb begin
    load     = !out_sel_n && !wr_n;
    rdata_oe = !in_sel_n && !rd_n;
    rdata    = rdata_oe ? gp_in : {DW{1'b1}};
  end

  always_ff @(posedge clk) begin
    if (rst)       gp_out <= '0;
    else if (load) gp_out <= wdata;
  end
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder
  import io_dec_pkg::*;
#(
  parameter bit DIR_QUAL = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              iorq_n,
  input  logic              m1_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] gp_in,
  output logic [GROUPS-1:0] sel_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic [ADDR_W-LO_W-1:0] hi_addr,
  output logic [DATA_W-1:0] gp_out,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);
  localparam logic [GROUPS-1:0] USED_WIN = 8'b1001_1111;
  localparam logic [GROUPS-1:0] RD_MASK  = GROUPS'(1) << IN_LINE;
  localparam logic [GROUPS-1:0] WR_MASK  = GROUPS'(1) << OUT_LINE;

  bus_ctl_t          ctl;
  logic [GROUPS-1:0] hit;
  logic              cyc_ok;

  assign ctl     = '{iorq_n: iorq_n, m1_n: m1_n, rd_n: rd_n, wr_n: wr_n};
  assign hi_addr = addr[ADDR_W-1:LO_W];

  io_window_decode #(.NGRP(GROUPS), .USED(USED_WIN)) win_i (
    .addr_lo (addr[LO_W-1:0]),
    .ctl     (ctl),
    .hit     (hit),
    .cyc_ok  (cyc_ok)
  );

  io_strobe_qual #(
    .NGRP(GROUPS), .DIR_QUAL(DIR_QUAL), .RD_ONLY(RD_MASK), .WR_ONLY(WR_MASK)
  ) qual_i (
    .hit     (hit),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .sel_n   (sel_n),
    .io_rd_n (io_rd_n),
    .io_wr_n (io_wr_n)
  );

  io_gp_ports #(.DW(DATA_W)) gp_i (
    .clk       (clk),
    .rst       (rst),
    .in_sel_n  (sel_n[IN_LINE]),
    .out_sel_n (sel_n[OUT_LINE]),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .wdata     (wdata),
    .gp_in     (gp_in),
    .gp_out    (gp_out),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe)
  );
endmodule

// File: rtl/io_port_decoder_chk.sv
module io_port_decoder_chk
  import io_dec_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              iorq_n,
  input logic              m1_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [DATA_W-1:0] wdata,
  input logic [GROUPS-1:0] sel_n,
  input logic              io_rd_n,
  input logic              io_wr_n,
  input logic [DATA_W-1:0] gp_out,
  input logic [DATA_W-1:0] rdata,
  input logic              rdata_oe
);
  logic unused_win;
  logic out_wr;
  assign unused_win = addr[7] || (addr[6:4] == 3'd5) || (addr[6:4] == 3'd6);
  assign out_wr     = !iorq_n && m1_n && (addr[7:4] == 4'h1) && !wr_n;

  assert_one_sel_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n));

  assert_intack_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!iorq_n && !m1_n) |-> (&sel_n && io_rd_n && io_wr_n && !rdata_oe));

  assert_unused_window_R3: assert property (@(posedge clk) disable iff (rst)
    unused_win |-> (&sel_n && !rdata_oe));

  assert_oe_needs_read_R6: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> (!rd_n && !sel_n[IN_LINE]));

  assert_latch_load_R7: assert property (@(posedge clk) disable iff (rst)
    out_wr |=> (gp_out == $past(wdata)));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !out_wr |=> $stable(gp_out));

  assert_pullup_R11: assert property (@(posedge clk) disable iff (rst)
    !rdata_oe |-> (rdata == 8'hFF));
endmodule

bind io_port_decoder io_port_decoder_chk chk_i (
  .clk(clk), .rst(rst), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
  .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .sel_n(sel_n),
  .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .gp_out(gp_out),
  .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/io_port_decoder_tb_top.sv
module io_port_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  wdata = 8'h00, gp_in = 8'h00;

  logic [7:0] sel_q, sel_c, hi_q, hi_c, out_q, out_c, rd_q, rd_c;
  logic       iord_q, iowr_q, oe_q, iord_c, iowr_c, oe_c;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  io_port_decoder #(.DIR_QUAL(1'b1)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .gp_in(gp_in),
    .sel_n(sel_q), .io_rd_n(iord_q), .io_wr_n(iowr_q), .hi_addr(hi_q),
    .gp_out(out_q), .rdata(rd_q), .rdata_oe(oe_q)
  );

  io_port_decoder #(.DIR_QUAL(1'b0)) dut_comb_i (
    .clk(clk), .rst(rst), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata), .gp_in(gp_in),
    .sel_n(sel_c), .io_rd_n(iord_c), .io_wr_n(iowr_c), .hi_addr(hi_c),
    .gp_out(out_c), .rdata(rd_c), .rdata_oe(oe_c)
  );

  task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s addr=%h ctl=%b%b%b%b actual=%h expected=%h",
               what, addr, iorq_n, m1_n, rd_n, wr_n, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(input bit q, input logic [7:0] a,
                                         input bit io, input bit m1,
                                         input bit rd, input bit wr);
    logic [7:0] s;
    int g;
    bit ok;
    s  = 8'hFF;
    g  = int'(a[6:4]);
    ok = 1'b1;
    if (!io && m1 && !a[7] && g != 5 && g != 6) begin
      if (q && g == 0) ok = !rd;
      if (q && g == 1) ok = !wr;
      if (ok) s[g] = 1'b0;
    end
    return s;
  endfunction

  task automatic idle();
    iorq_n = 1'b1; m1_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
  endtask

  initial begin : watchdog
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] es, ds;
    bit         valid, win_ok, eoe;
    repeat (3) @(negedge clk);
    #1;
    chk("R8 reset gp_out qual", {8'h0, out_q}, 16'h0000);
    chk("R8 reset gp_out comb", {8'h0, out_c}, 16'h0000);
    @(negedge clk);
    rst = 1'b0;

    for (int lo = 0; lo < 256; lo++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        addr   = {8'(lo * 37 + c * 11), 8'(lo)};
        iorq_n = c[3]; m1_n = c[2]; rd_n = c[1]; wr_n = c[0];
        gp_in  = 8'(lo ^ (c * 19));
        wdata  = 8'(lo + c);
        #1;
        valid  = !iorq_n && m1_n;
        win_ok = !addr[7] && addr[6:4] != 3'd5 && addr[6:4] != 3'd6;
        eoe    = valid && addr[7:4] == 4'h0 && !rd_n;
        es = exp_sel(1'b1, addr[7:0], iorq_n, m1_n, rd_n, wr_n);
        ds = exp_sel(1'b0, addr[7:0], iorq_n, m1_n, rd_n, wr_n);
        chk("R1 R2 R3 R4 sel qual", {8'h0, sel_q}, {8'h0, es});
        chk("R1 R2 R3 R4 sel comb", {8'h0, sel_c}, {8'h0, ds});
        chk("R10 strobes qual", {14'h0, iord_q, iowr_q},
            {14'h0, !(valid && win_ok && !rd_n), !(valid && win_ok && !wr_n)});
        chk("R10 strobes comb", {14'h0, iord_c, iowr_c},
            {14'h0, !(valid && win_ok && !rd_n), !(valid && win_ok && !wr_n)});
        chk("R5 R6 oe qual", {15'h0, oe_q}, {15'h0, eoe});
        chk("R5 R6 oe comb", {15'h0, oe_c}, {15'h0, eoe});
        chk("R5 R11 rdata qual", {8'h0, rd_q}, {8'h0, eoe ? gp_in : 8'hFF});
        chk("R5 R11 rdata comb", {8'h0, rd_c}, {8'h0, eoe ? gp_in : 8'hFF});
        chk("R9 hi_addr", {hi_q, hi_c}, {addr[15:8], addr[15:8]});
      end
    end

    // R7 write to output window
    @(negedge clk);
    addr = 16'h7713; wdata = 8'hA5; iorq_n = 0; m1_n = 1; rd_n = 1; wr_n = 0;
    @(negedge clk); idle(); #1;
    chk("R7 load qual", {8'h0, out_q}, 16'h00A5);
    chk("R7 load comb", {8'h0, out_c}, 16'h00A5);

    // R7 write elsewhere holds
    addr = 16'h0023; wdata = 8'h3C; iorq_n = 0; wr_n = 0;
    @(negedge clk); idle(); #1;
    chk("R7 hold other window", {out_q, out_c}, 16'hA5A5);

    // R2 interrupt acknowledge at output window
    addr = 16'h0010; wdata = 8'h77; iorq_n = 0; m1_n = 0; wr_n = 0;
    @(negedge clk); idle(); #1;
    chk("R2 intack no load", {out_q, out_c}, 16'hA5A5);

    // R7 read cycle at output window does not load
    addr = 16'h0010; wdata = 8'h5A; iorq_n = 0; rd_n = 0;
    @(negedge clk); idle(); #1;
    chk("R7 read no load", {out_q, out_c}, 16'hA5A5);

    // R6 write to input window: no drive
    addr = 16'hFF05; gp_in = 8'h12; iorq_n = 0; wr_n = 0; #1;
    chk("R6 write input window oe", {14'h0, oe_q, oe_c}, 16'h0000);
    chk("R11 write input window rdata", {rd_q, rd_c}, 16'hFFFF);
    @(negedge clk); idle();

    // R8 reset mid-run
    rst = 1'b1;
    @(negedge clk); #1;
    chk("R8 mid-run reset", {out_q, out_c}, 16'h0000);
    rst = 1'b0;
    @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule